// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Set-on-Less-Than

This block is a purely combinational arithmetic and logic unit for a 32-bit datapath. It is built from one identical slice per bit. Each slice holds a bitwise AND, a bitwise OR and a full adder, plus a selector that picks which of these becomes its result bit. Subtraction uses the same adders. The B operand is inverted and the carry entering the lowest slice is forced to 1, so the adders form A + NOT B + 1.

Set-on-less-than needs no extra comparator. The sum bit of the most significant slice is routed back to the "less" input of slice 0, and every other slice sees a constant 0 on that input. The bitwise NOR of the result gives a zero flag, which is used for equality branches. The carry leaving the top slice is also brought out.

The operation select has four bits. Bit 3 must be 0 for a supported code. Bit 2 inverts B and forces the low carry-in to 1. Bits 1:0 choose the slice function: 00 AND, 01 OR, 10 adder sum, 11 less. The named operations are AND 0000, OR 0001, add 0010, subtract 0110 and set-on-less-than 0111.

Top module: `alu_sliced32`

## Requirements
- R1: When op_sel[3]=0 and op_sel[1:0]=00, result is opa AND opb'. Here opb' is opb when op_sel[2]=0 and NOT opb when op_sel[2]=1 (code 0000 is AND, code 0100 is opa AND NOT opb).
- R2: When op_sel[3]=0 and op_sel[1:0]=01, result is opa OR opb', with opb' as in R1 (code 0001 is OR, code 0101 is opa OR NOT opb).
- R3: With op_sel=0010, result is (opa + opb) mod 2^32 and carry_out is bit 32 of the unsigned sum.
- R4: With op_sel=0110, result is (opa + NOT opb + 1) mod 2^32, which is opa − opb. carry_out is the carry leaving bit 31, so it is 1 exactly when opa ≥ opb unsigned.
- R5: With op_sel=0111, result bits 31 to 1 are 0 and bit 0 equals bit 31 of opa − opb. No overflow correction is made, so opa=0x7FFFFFFF with opb=0x80000000 gives result 1.
- R6: zero is 1 exactly when all 32 result bits are 0, for every op_sel value.
- R7: When op_sel[3]=1, result is 0 and zero is 1, whatever the operands are.
- R8: The outputs depend only on the present inputs and hold no state. Applying the same inputs again gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand, inverted for subtract and set-on-less-than |
| op_sel | input | 4 | Operation select: bit 3 unsupported flag, bit 2 invert-B with carry-in 1, bits 1:0 slice function |
| result | output | 32 | Selected slice results |
| zero | output | 1 | 1 when result is all zeros |
| carry_out | output | 1 | Carry leaving the most significant slice |

## Verification
The assertions are evaluated whenever the inputs change. They check that the zero flag agrees with the result. For add and subtract they check the sum and carry against a wide arithmetic reference. For set-on-less-than they check that only bit 0 can be set and that it carries the difference's sign. For unsupported codes they check that the result is cleared. The bench covers what those properties do not: the AND and OR variants with inverted B, the fixed vectors where carries ripple across the full width, the raw-sign corner of set-on-less-than that gives the wrong signed answer, and the reapplication of earlier inputs that shows the block holds no state.

// File: rtl/alu_slice_pkg.sv
`timescale 1ns/1ps
// Package: shared slice function encoding and one-bit full-adder equations.
// Assumes the encoding of op_sel[1:0] listed in the brief.
package alu_slice_pkg;

    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_ADD  = 2'b10,
        FN_LESS = 2'b11
    } slice_fn_e;

    // Full-adder carry: AB + (A xor B)Cin
    function automatic logic fa_carry(input logic x, input logic y, input logic c);
        return (x & y) | ((x ^ y) & c);
    endfunction

    // Full-adder sum: A xor B xor Cin
    function automatic logic fa_sum(input logic x, input logic y, input logic c);
        return x ^ y ^ c;
    endfunction

endpackage

// File: rtl/alu_op_decode.sv
`timescale 1ns/1ps
// Module: splits the 4-bit operation select into slice controls.
// Assumes bit 3 flags an unsupported code, bit 2 inverts B and forces carry-in,
// and bits 1:0 pick the slice function.
module alu_op_decode
    import alu_slice_pkg::*;
(
    input  logic [3:0] op_sel,
    output logic       b_invert,
    output slice_fn_e  fn,
    output logic       kill
);

    // Purpose: map select bits onto control lines.
    always_comb begin
        b_invert = op_sel[2];
        fn       = slice_fn_e'(op_sel[1:0]);
        kill     = op_sel[3];
    end

    // Set-on-less-than must subtract (R5)
    always_comb begin
        if (op_sel == 4'b0111) begin
            assert_slt_subtracts_R5: assert (b_invert && fn == FN_LESS)
                else $error("slt decode does not subtract");
        end
    end

endmodule

// File: rtl/alu_carry_chain.sv
`timescale 1ns/1ps
// Module: ripple carry chain across W slices using the full-adder carry equation.
// Assumes b_eff already carries any inversion; carry[0] is the injected carry-in.
module alu_carry_chain
    import alu_slice_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b_eff,
    input  logic         cin,
    output logic [W:0]   carry
);

    // Purpose: ripple the carry from the lowest slice to the top.
    always_comb begin
        logic [W:0] c;
        c[0] = cin;
        for (int i = 0; i < W; i++) begin
            c[i+1] = fa_carry(a[i], b_eff[i], c[i]);
        end
        carry = c;
    end

endmodule

// File: rtl/alu_bit_slice.sv
`timescale 1ns/1ps
// Module: one ALU bit. Holds AND, OR, full-adder sum and a result selector.
// Assumes b_eff is already inverted when subtracting; kill clears the result.
module alu_bit_slice
    import alu_slice_pkg::*;
(
    input  logic      a,
    input  logic      b_eff,
    input  logic      cin,
    input  logic      less,
    input  slice_fn_e fn,
    input  logic      kill,
    output logic      res,
    output logic      sum
);

    // Purpose: form the adder sum of this bit.
    always_comb sum = fa_sum(a, b_eff, cin);

    // Purpose: select this bit's result from the slice functions.
    always_comb begin
        unique case (fn)
            FN_AND:  res = a & b_eff;
            FN_OR:   res = a | b_eff;
            FN_ADD:  res = sum;
            FN_LESS: res = less;
            default: res = 1'b0;
        endcase
        if (kill) res = 1'b0;
    end

endmodule

// File: rtl/alu_zero_detect.sv
`timescale 1ns/1ps
// Module: flags an all-zero word by inverting the OR of its bits.
// Assumes nothing about the source of the word.
module alu_zero_detect #(
    parameter int W = 32
) (
    input  logic [W-1:0] v,
    output logic         zero
);

    // Purpose: NOR-reduce the word.
    always_comb zero = ~(|v);

endmodule

// File: rtl/alu_sliced32.sv
`timescale 1ns/1ps
// Module: W-bit combinational ALU built from W identical slices.
// Assumes W >= 2. The top slice's sum drives the less input of slice 0; the
// other less inputs are 0. Outputs depend only on the present inputs.
module alu_sliced32
    import alu_slice_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [3:0]   op_sel,
    output logic [W-1:0] result,
    output logic         zero,
    output logic         carry_out
);

    localparam int MSB = W - 1;

    logic          b_invert;
    slice_fn_e     fn;
    logic          kill;
    logic [W-1:0]  b_eff;
    logic [W:0]    carry;
    logic [W-1:0]  sum_all;
    logic          set_msb;

    alu_op_decode u_dec (
        .op_sel   (op_sel),
        .b_invert (b_invert),
        .fn       (fn),
        .kill     (kill)
    );

    // Purpose: conditionally invert the B operand for all slices.
    always_comb b_eff = opb ^ {W{b_invert}};

    alu_carry_chain #(.W(W)) u_chain (
        .a     (opa),
        .b_eff (b_eff),
        .cin   (b_invert),
        .carry (carry)
    );

    // Purpose: pick the sign of the top slice as the set-on-less-than bit.
    always_comb set_msb = sum_all[MSB];

    for (genvar i = 0; i < W; i++) begin : g_slice
        logic less_in;
        if (i == 0) begin : g_lsb
            always_comb less_in = set_msb;
        end else begin : g_upper
            always_comb less_in = 1'b0;
        end
        alu_bit_slice u_slice (
            .a     (opa[i]),
            .b_eff (b_eff[i]),
            .cin   (carry[i]),
            .less  (less_in),
            .fn    (fn),
            .kill  (kill),
            .res   (result[i]),
            .sum   (sum_all[i])
        );
    end

    alu_zero_detect #(.W(W)) u_zero (
        .v    (result),
        .zero (zero)
    );

    // Purpose: bring out the carry leaving the top slice.
    always_comb carry_out = carry[W];

    // Purpose: check outputs against wide arithmetic whenever inputs change.
    always_comb begin
        logic [W:0]   wide_add;
        logic [W-1:0] diff;
        wide_add = {1'b0, opa} + {1'b0, opb};
        diff     = opa - opb;
        assert_zero_flag_R6: assert (zero == (result == '0))
            else $error("zero flag disagrees with result");
        if (op_sel == 4'b0010) begin
            assert_add_sum_R3: assert ({carry_out, result} == wide_add)
                else $error("add result mismatch");
        end
        if (op_sel == 4'b0110) begin
            assert_sub_diff_R4: assert (result == diff && carry_out == (opa >= opb))
                else $error("subtract result mismatch");
        end
        if (op_sel == 4'b0111) begin
            assert_slt_bits_R5: assert (result[MSB:1] == '0 && result[0] == diff[MSB])
                else $error("set-on-less-than result mismatch");
        end
        if (op_sel[3]) begin
            assert_kill_clear_R7: assert (result == '0)
                else $error("unsupported code left result non-zero");
        end
    end

endmodule

// File: tb/test_alu_sliced32.sv
`timescale 1ns/1ps
// Bench: vector table walk, model-based sweeps and directed corner tests.
module test_alu_sliced32;

    logic        clk = 1'b0;
    logic [31:0] opa, opb, result;
    logic [3:0]  op_sel;
    logic        zero, carry_out;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 0;

    always #4 clk = ~clk;

    alu_sliced32 i_alu_sliced32 (
        .opa       (opa),
        .opb       (opb),
        .op_sel    (op_sel),
        .result    (result),
        .zero      (zero),
        .carry_out (carry_out)
    );

    // entry: {req, op, a, b, exp_result, check_cout, exp_cout}
    localparam int NV = 20;
    localparam logic [105:0] VEC [NV] = '{
        {4'd1, 4'b0000, 32'hF0F01234, 32'h0FF0FF00, 32'h00F01200, 1'b0, 1'b0}, // R1
        {4'd1, 4'b0100, 32'hFFFF0000, 32'h0F0F0F0F, 32'hF0F00000, 1'b0, 1'b0}, // R1
        {4'd2, 4'b0001, 32'h12000034, 32'h00345600, 32'h12345634, 1'b0, 1'b0}, // R2
        {4'd2, 4'b0101, 32'h00000000, 32'hFFFFFFF0, 32'h0000000F, 1'b0, 1'b0}, // R2
        {4'd3, 4'b0010, 32'h00000001, 32'h00000002, 32'h00000003, 1'b1, 1'b0}, // R3
        {4'd3, 4'b0010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b1}, // R3
        {4'd3, 4'b0010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1}, // R3
        {4'd3, 4'b0010, 32'h12345678, 32'h11111111, 32'h23456789, 1'b1, 1'b0}, // R3
        {4'd4, 4'b0110, 32'h00000005, 32'h00000003, 32'h00000002, 1'b1, 1'b1}, // R4
        {4'd4, 4'b0110, 32'h00000003, 32'h00000005, 32'hFFFFFFFE, 1'b1, 1'b0}, // R4
        {4'd4, 4'b0110, 32'h00000007, 32'h00000007, 32'h00000000, 1'b1, 1'b1}, // R4
        {4'd4, 4'b0110, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b1, 1'b0}, // R4
        {4'd5, 4'b0111, 32'h00000003, 32'h00000005, 32'h00000001, 1'b0, 1'b0}, // R5
        {4'd5, 4'b0111, 32'h00000005, 32'h00000003, 32'h00000000, 1'b0, 1'b0}, // R5
        {4'd5, 4'b0111, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0}, // R5
        {4'd5, 4'b0111, 32'h7FFFFFFF, 32'h80000000, 32'h00000001, 1'b0, 1'b0}, // R5 raw sign
        {4'd5, 4'b0111, 32'h80000000, 32'h00000001, 32'h00000000, 1'b0, 1'b0}, // R5 raw sign
        {4'd5, 4'b0111, 32'h00000009, 32'h00000009, 32'h00000000, 1'b0, 1'b0}, // R5
        {4'd7, 4'b1010, 32'h00000001, 32'h00000002, 32'h00000000, 1'b0, 1'b0}, // R7
        {4'd7, 4'b1111, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b0, 1'b0}  // R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Drive after a rising edge, let the logic settle to the falling edge.
    task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        op_sel = o; opa = a; opb = b;
        @(negedge clk);
    endtask

    function automatic logic [32:0] model(input logic [3:0] o, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [31:0] bb;
        logic [32:0] s;
        bb = o[2] ? ~b : b;
        s  = {1'b0, a} + {1'b0, bb} + {32'd0, o[2]};
        if (o[3]) return {s[32], 32'd0};
        case (o[1:0])
            2'b00:   return {s[32], a & bb};
            2'b01:   return {s[32], a | bb};
            2'b10:   return s;
            default: return {s[32], 31'd0, s[31]};
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr_a, lfsr_b;
        logic [32:0] m;
        logic [31:0] keep_res;
        logic [3:0]  ops [5];
        op_sel = 4'b0000; opa = '0; opb = '0;
        ops[0] = 4'b0000; ops[1] = 4'b0001; ops[2] = 4'b0010;
        ops[3] = 4'b0110; ops[4] = 4'b0111;

        // Initial all-zero inputs: AND of zeros, zero flag high (R1, R6)
        @(negedge clk);
        check("R1 idle result", result, 32'h0);
        check("R6 idle zero", {31'd0, zero}, 32'h1);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [105:0] e;
            string tag;
            e = VEC[i];
            tag = $sformatf("R%0d vec%0d", e[105:102], i);
            apply(e[101:98], e[97:66], e[65:34]);
            check(tag, result, e[33:2]);
            check({"R6 zero ", tag}, {31'd0, zero}, {31'd0, (e[33:2] == 32'd0)});
            if (e[1]) check({"cout ", tag}, {31'd0, carry_out}, {31'd0, e[0]});
        end

        // Model sweep over the named operations (R1 R2 R3 R4 R5 R6)
        lfsr_a = 32'hACE1_2468;
        lfsr_b = 32'h1357_9BDF;
        for (int k = 0; k < 200; k++) begin
            lfsr_a = lfsr_a ^ (lfsr_a << 13); lfsr_a = lfsr_a ^ (lfsr_a >> 17);
            lfsr_a = lfsr_a ^ (lfsr_a << 5);
            lfsr_b = lfsr_b ^ (lfsr_b << 13); lfsr_b = lfsr_b ^ (lfsr_b >> 17);
            lfsr_b = lfsr_b ^ (lfsr_b << 5);
            for (int j = 0; j < 5; j++) begin
                apply(ops[j], lfsr_a, (k % 16 == 0) ? lfsr_a : lfsr_b);
                m = model(ops[j], opa, opb);
                check("R1..R5 sweep result", result, m[31:0]);
                check("R6 sweep zero", {31'd0, zero}, {31'd0, (m[31:0] == 32'd0)});
                if (ops[j] == 4'b0010 || ops[j] == 4'b0110)
                    check("R3/R4 sweep cout", {31'd0, carry_out}, {31'd0, m[32]});
            end
        end

        // Unsupported code with all-ones operands (R7)
        apply(4'b1001, 32'hFFFFFFFF, 32'hFFFFFFFF);
        check("R7 kill result", result, 32'h0);
        check("R7 kill zero", {31'd0, zero}, 32'h1);

        // Stateless: reapply inputs after unrelated ones (R8)
        apply(4'b0110, 32'h0000_1000, 32'h0000_0001);
        keep_res = result;
        check("R8 first apply", keep_res, 32'h0000_0FFF);
        apply(4'b0010, 32'hFFFFFFFF, 32'hFFFFFFFF);
        apply(4'b0110, 32'h0000_1000, 32'h0000_0001);
        check("R8 reapply", result, keep_res);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule